// File: doc/BRIEF.md
# USB Full-Speed Frame Interval Timer

This block keeps the frame timing for a full-speed USB host. A down-counter walks through the bit times of the current frame. When it reaches zero it reloads from a programmable interval, advances a 16-bit frame number and raises a one-cycle start-of-frame strobe. A second one-cycle strobe marks each change of the frame number's top bit.

The block also compares the live countdown against a periodic-start threshold. The resulting flag tells the list scheduler that periodic traffic now has priority for the rest of the frame. Software writes the interval word and the threshold. It reads back the interval word, the remaining-time word and the frame number. Counting happens only while the `run` input is high.

Top module: `usb_frame_timer`

## Requirements
- R1: After reset the remaining count is 11999, the frame number is 0, the interval word reads 11999 with all other bits 0, the threshold is 0, and both strobes are low.
- R2: While `run` is low, the remaining word and the frame number keep their values, and neither strobe is raised.
- R3: While `run` is high and the remaining count (rem_rdata bits 13:0) is not zero, that count drops by one on each clock.
- R4: While `run` is high, a clock edge that sees a remaining count of zero does three things. It reloads the count from interval bits 13:0 and adds one (mod 2^16) to the frame number. It also raises `sof` for exactly the following cycle.
- R5: Remaining-word bit 31 takes the value of interval-word bit 31 at each reload, and changes at no other time.
- R6: An interval write stores bit 31 (toggle), bits 30:16 (max packet size) and bits 13:0 (interval), and bits 15:14 read back as 0. The write does not alter the running count; the new interval takes effect at the next reload.
- R7: `fno` is high for exactly the cycle in which `sof` follows a reload that changed frame-number bit 15, which covers 0x7FFF to 0x8000 and 0xFFFF to 0x0000.
- R8: `periodic_pri` is high exactly when the remaining count is less than or equal to the threshold.
- R9: Bits 30:14 of the remaining word always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run | input | 1 | Enables frame counting |
| ivl_we | input | 1 | Write strobe for the interval word |
| ivl_wdata | input | 32 | Interval word: toggle, max packet size, interval |
| pst_we | input | 1 | Write strobe for the periodic-start threshold |
| pst_wdata | input | 14 | Periodic-start threshold in bit times |
| ivl_rdata | output | 32 | Interval word readback |
| rem_rdata | output | 32 | Remaining-time word: toggle at bit 31, count at bits 13:0 |
| frame_num | output | 16 | Frame number |
| sof | output | 1 | Start-of-frame strobe, one cycle |
| fno | output | 1 | Frame-number bit-15 change strobe, one cycle |
| periodic_pri | output | 1 | Periodic traffic has priority |

## Verification
The bench sweeps every interval from 0 to 6 against every threshold from 0 to 7, flipping the toggle bit between runs. This separates off-by-one errors in the reload point, in the frame length and in the threshold comparison. Interval writes made mid-frame, followed by pauses on `run`, tell a correct deferred reload apart from an immediate one. They also show that the count truly holds while `run` is low. A one-cycle-per-frame run through all 65536 frame numbers reaches both edges of bit 15 and shows that no other frame raises `fno`.

// File: rtl/usb_frame_timer.sv
module usb_frame_timer #(
  parameter int FI_W = 14,
  parameter int MPS_W = 15,
  parameter int unsigned FI_RESET = 11999
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            ivl_we,
  input  logic [31:0]     ivl_wdata,
  input  logic            pst_we,
  input  logic [FI_W-1:0] pst_wdata,
  output logic [31:0]     ivl_rdata,
  output logic [31:0]     rem_rdata,
  output logic [15:0]     frame_num,
  output logic            sof,
  output logic            fno,
  output logic            periodic_pri
);
  localparam int GAP_W = 16 - FI_W;
  localparam int REM_GAP = 31 - FI_W;

  logic [FI_W-1:0]  ivl_fi, pst, rem;
  logic [MPS_W-1:0] ivl_mps;
  logic             ivl_tog, rem_tog;
  logic [15:0]      frame_nxt;

  wire at_end = (rem == '0);
  assign frame_nxt = frame_num + 16'd1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ivl_fi  <= FI_W'(FI_RESET);
      ivl_mps <= '0;
      ivl_tog <= 1'b0;
      pst     <= '0;
    end else begin
      if (ivl_we) begin
        ivl_fi  <= ivl_wdata[FI_W-1:0];
        ivl_mps <= ivl_wdata[16 +: MPS_W];
        ivl_tog <= ivl_wdata[31];
      end
      if (pst_we) pst <= pst_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem       <= FI_W'(FI_RESET);
      rem_tog   <= 1'b0;
      frame_num <= '0;
      sof       <= 1'b0;
      fno       <= 1'b0;
    end else begin
      sof <= 1'b0;
      fno <= 1'b0;
      if (run) begin
        if (at_end) begin
          rem       <= ivl_fi;
          rem_tog   <= ivl_tog;
          frame_num <= frame_nxt;
          sof       <= 1'b1;
          fno       <= frame_nxt[15] ^ frame_num[15];
        end else begin
          rem <= rem - 1'b1;
        end
      end
    end
  end

  assign ivl_rdata    = {ivl_tog, ivl_mps, {GAP_W{1'b0}}, ivl_fi};
  assign rem_rdata    = {rem_tog, {REM_GAP{1'b0}}, rem};
  assign periodic_pri = (rem <= pst);
endmodule

// File: rtl/usb_frame_timer_chk.sv
module usb_frame_timer_chk #(
  parameter int FI_W = 14
) (
  input logic        clk,
  input logic        rst_n,
  input logic        run,
  input logic [31:0] rem_rdata,
  input logic [15:0] frame_num,
  input logic        sof,
  input logic        fno
);
  wire [FI_W-1:0] cnt = rem_rdata[FI_W-1:0];

  a_r3_countdown: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt != '0) |=> (cnt == FI_W'($past(cnt) - 1'b1)));

  a_r4_sof_after_zero: assert property (@(posedge clk) disable iff (!rst_n)
    sof |-> ($past(run) && $past(cnt) == '0));

  a_r4_frame_step: assert property (@(posedge clk) disable iff (!rst_n)
    sof |-> (frame_num == 16'($past(frame_num) + 16'd1)));

  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> ($stable(rem_rdata) && $stable(frame_num) && !sof && !fno));

  a_r7_fno_edge: assert property (@(posedge clk) disable iff (!rst_n)
    fno |-> (sof && frame_num[14:0] == 15'd0));

  a_r5_toggle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !sof |-> $stable(rem_rdata[31]));

  a_r9_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rem_rdata[30:FI_W] == '0);
endmodule

bind usb_frame_timer usb_frame_timer_chk #(.FI_W(FI_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .rem_rdata(rem_rdata),
  .frame_num(frame_num), .sof(sof), .fno(fno)
);

// File: tb/usb_frame_timer_test.sv
`timescale 1ns/1ps
module usb_frame_timer_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 1'b0, ivl_we = 1'b0, pst_we = 1'b0;
  logic [31:0] ivl_wdata = '0;
  logic [13:0] pst_wdata = '0;
  logic [31:0] ivl_rdata, rem_rdata;
  logic [15:0] frame_num;
  logic sof, fno, periodic_pri;

  int checks = 0, failures = 0;
  int m_rem, m_fn, m_pst, fno_seen;
  logic [31:0] m_ivl;
  logic m_tog, m_sof, m_fno;

  always #5 clk = ~clk;

  usb_frame_timer uut (
    .clk(clk), .rst_n(rst_n), .run(run), .ivl_we(ivl_we), .ivl_wdata(ivl_wdata),
    .pst_we(pst_we), .pst_wdata(pst_wdata), .ivl_rdata(ivl_rdata),
    .rem_rdata(rem_rdata), .frame_num(frame_num), .sof(sof), .fno(fno),
    .periodic_pri(periodic_pri)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic verify();
    chk("R3 count", {18'd0, rem_rdata[13:0]}, m_rem);
    chk("R4 frame", {16'd0, frame_num}, m_fn);
    chk("R4 sof", {31'd0, sof}, {31'd0, m_sof});
    chk("R7 fno", {31'd0, fno}, {31'd0, m_fno});
    chk("R5 toggle", {31'd0, rem_rdata[31]}, {31'd0, m_tog});
    chk("R9 upper", {15'd0, rem_rdata[30:14]}, 32'd0);
    chk("R6 readback", ivl_rdata, m_ivl);
    chk("R8 priority", {31'd0, periodic_pri}, {31'd0, (m_rem <= m_pst)});
    if (fno) fno_seen++;
  endtask

  task automatic cyc(input logic r, input logic iw, input logic [31:0] id,
                     input logic pw, input logic [13:0] pd);
    int nf;
    run = r; ivl_we = iw; ivl_wdata = id; pst_we = pw; pst_wdata = pd;
    @(posedge clk);
    m_sof = 1'b0; m_fno = 1'b0;
    if (r) begin
      if (m_rem == 0) begin
        nf = (m_fn + 1) % 65536;
        m_fno = ((nf / 32768) != (m_fn / 32768));
        m_fn = nf; m_rem = int'(m_ivl[13:0]); m_tog = m_ivl[31]; m_sof = 1'b1;
      end else m_rem = m_rem - 1;
    end
    if (iw) m_ivl = id & 32'hFFFF_3FFF;
    if (pw) m_pst = int'(pd);
    @(negedge clk);
    ivl_we = 1'b0; pst_we = 1'b0;
    verify();
  endtask

  initial begin
    #3_000_000;
    failures++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] held;
    m_rem = 11999; m_fn = 0; m_pst = 0; m_ivl = 32'd11999; m_tog = 1'b0;
    m_sof = 1'b0; m_fno = 1'b0; fno_seen = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 remaining", rem_rdata, 32'd11999);
    chk("R1 frame", {16'd0, frame_num}, 32'd0);
    chk("R1 interval", ivl_rdata, 32'd11999);
    chk("R1 strobes", {30'd0, sof, fno}, 32'd0);
    chk("R1 threshold", {31'd0, periodic_pri}, 32'd0);

    // R2 idle holds everything
    for (int i = 0; i < 5; i++) begin
      cyc(1'b0, 1'b0, 0, 1'b0, 0);
      chk("R2 hold", rem_rdata, 32'd11999);
    end

    // R6 write with reserved bits set; count unaffected
    cyc(1'b0, 1'b1, 32'hC040_C003, 1'b1, 14'd2);
    chk("R6 masked", ivl_rdata, 32'hC040_0003);
    chk("R6 count untouched", rem_rdata, 32'd11999);

    // run out the long reset frame
    for (int i = 0; i < 12010; i++) cyc(1'b1, 1'b0, 0, 1'b0, 0);

    // sweep intervals and thresholds, toggling bit 31
    for (int n = 0; n <= 6; n++) begin
      for (int p = 0; p <= 7; p++) begin
        cyc(1'b1, 1'b1, {((n + p) % 2 == 1), 15'd8, 2'd0, 14'(n)}, 1'b1, 14'(p));
        for (int k = 0; k < 3 * (n + 1) + 2; k++) cyc(1'b1, 1'b0, 0, 1'b0, 0);
        // R2 pause mid-frame
        held = rem_rdata;
        for (int k = 0; k < 3; k++) begin
          cyc(1'b0, 1'b0, 0, 1'b0, 0);
          chk("R2 paused", rem_rdata, held);
        end
      end
    end

    // R7 walk through every frame number with one cycle per frame
    cyc(1'b1, 1'b1, 32'd0, 1'b0, 0);
    for (int i = 0; i < 10; i++) cyc(1'b1, 1'b0, 0, 1'b0, 0);
    fno_seen = 0;
    for (int i = 0; i < 65536; i++) cyc(1'b1, 1'b0, 0, 1'b0, 0);
    chk("R7 two edges", fno_seen, 32'd2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule